// File: doc/BRIEF.md
# Dual Parallel Port Group GPIO with Edge Interrupt

This block offers 48 general-purpose pins, arranged as two identical groups of 24. Each group has three 8-bit ports, called A, B and C, which work like a basic parallel peripheral interface with no handshaking. A simple synchronous register bus carries a 4-bit offset, read and write strobes, and 8-bit data. Software uses this bus to set pin directions, load output latches and read pin levels.

Each group has one control register. A control write with bit 7 set is a mode-set command. It sets the direction of whole ports A and B, and of each 4-bit half of port C. Every mode-set also clears the output latches of that group. On a read of a data port, output bits return their latched value and input bits return the pin level after a two-flop synchronizer.

Pin 3 of each port C is an interrupt source. Synchronized rising edges on these pins set a pending flag, but only while interrupts are enabled. A single request line stays high for as long as either flag is pending. Any write to offset 0xB enables interrupts, and any read of offset 0xB disables them. Any write to offset 0xF clears both pending flags.

Top module: `dual_ppi_gpio`

## Requirements
- R1: After reset every pin is an input (`pinOe` all zero), every output latch is zero (`pinOut` all zero), interrupts are disabled and `irqReq` is low.
- R2: A write to a data port updates that port's 8-bit latch on the next clock edge. The data ports are at offsets 0, 1 and 2 (ports A, B, C of group 0) and 4, 5 and 6 (group 1). Port p of group g drives `pinOut[24g+8p +: 8]` from its latch.
- R3: A write to the control register (offset 3 for group 0, offset 7 for group 1) with bit 7 set loads that group's directions. Bit 4 makes port A an input, bit 1 makes port B an input, bit 3 makes the upper nibble of port C an input, and bit 0 makes the lower nibble an input. A cleared bit makes that part an output, which sets the matching `pinOe` bits.
- R4: A control write with bit 7 clear changes no direction and no latch.
- R5: A mode-set command clears all three latches of its own group to zero and leaves the other group's latches unchanged.
- R6: A read of a data port returns its byte on `busRdata` after the next clock edge. Each bit is the latch value if the bit is an output, or the synchronized pin value if it is an input.
- R7: A read of offset 3, offset 7 or any offset from 8 to 15 returns 0xFF.
- R8: While interrupts are enabled, a rising edge on pin 19 (group 0, port C bit 3) or pin 43 (group 1, port C bit 3) raises `irqReq` on the third clock edge after the pin changes.
- R9: A read of offset 0xB disables interrupts. Rising edges that arrive while interrupts are disabled are not recorded, and enabling again later does not raise `irqReq` for them.
- R10: A write to offset 0xF forces `irqReq` low on the next edge. The clear takes priority over a new edge in the same cycle.
- R11: Once raised, `irqReq` stays high until it is cleared, even when the source pin falls. Falling edges and edges on other pins never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register offset |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| pinIn | input | 48 | Pin levels from the pads |
| pinOut | output | 48 | Output latch values |
| pinOe | output | 48 | Output enable per pin, 1 = drive |
| irqReq | output | 1 | Interrupt request, level |

## Verification
Direction and latch writes show up on `pinOe` and `pinOut` one edge after the write strobe, so the bench checks them on the falling edge that follows that edge. Read data is registered and is sampled one edge after the read strobe. Before every read, a pin change is given three edges to pass through the synchronizer. The interrupt path is checked twice after a source edge: at two edges it must still be low, and at three edges it must be high. This pins down the latency exactly. Clears and disables are checked several cycles later, which proves the state holds.

// File: rtl/dppi_pkg.sv
package dppi_pkg;
  // Strobes passed from bus decode to the port datapath
  typedef struct packed {
    logic       dataWr;   // write to a data port latch
    logic       modeWr;   // mode-set command (control write with bit 7 set)
    logic       rdEn;     // capture read data this cycle
    logic       rdIsData; // read targets a data port (else 0xFF)
    logic       grpSel;   // addressed group
    logic [1:0] portSel;  // addressed port within the group
  } ppiStrobe_t;
endpackage

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import dppi_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_GRP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              modeFlag,
  input  logic [NUM_GRP-1:0] srcEdge,
  output ppiStrobe_t        strb,
  output logic              irqReq
);
  localparam logic [ADDR_W-1:0] EN_OFF  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] CLR_OFF = ADDR_W'(15);

  logic isCtl, inLow;
  logic irqEn;
  logic [NUM_GRP-1:0] pendQ;

  assign isCtl = (busAddr[1:0] == 2'd3);
  assign inLow = (busAddr[ADDR_W-1:3] == '0);

  always_comb begin
    strb.grpSel   = busAddr[2];
    strb.portSel  = busAddr[1:0];
    strb.dataWr   = busWr & inLow & ~isCtl;
    strb.modeWr   = busWr & inLow & isCtl & modeFlag;
    strb.rdEn     = busRd;
    strb.rdIsData = inLow & ~isCtl;
  end

  // enable: write 0xB sets, read 0xB clears
  always_ff @(posedge clk) begin
    if (!rstN)                             irqEn <= 1'b0;
    else if (busWr && busAddr == EN_OFF)   irqEn <= 1'b1;
    else if (busRd && busAddr == EN_OFF)   irqEn <= 1'b0;
  end

  // pending flags: clear wins over a same-cycle edge
  always_ff @(posedge clk) begin
    if (!rstN)                             pendQ <= '0;
    else if (busWr && busAddr == CLR_OFF)  pendQ <= '0;
    else                                   pendQ <= pendQ | (srcEdge & {NUM_GRP{irqEn}});
  end

  assign irqReq = |pendQ;
endmodule

// File: rtl/ppi_datapath.sv
module ppi_datapath
  import dppi_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int NUM_GRP = 2,
  parameter int IRQ_BIT = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ppiStrobe_t                     strb,
  input  logic [PORT_W-1:0]              busWdata,
  input  logic [NUM_GRP*3*PORT_W-1:0]    pinIn,
  output logic [NUM_GRP*3*PORT_W-1:0]    pinOut,
  output logic [NUM_GRP*3*PORT_W-1:0]    pinOe,
  output logic [PORT_W-1:0]              busRdata,
  output logic [NUM_GRP-1:0]             srcEdge
);
  localparam int GRP_W = 3 * PORT_W;
  localparam int PIN_W = NUM_GRP * GRP_W;
  localparam int HALF  = PORT_W / 2;

  logic [PIN_W-1:0] syncA, syncB, rdView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    logic [3:0]       dirIn;   // {A, B, C upper, C lower}, 1 = input
    logic [GRP_W-1:0] latchQ;
    logic             prevQ;
    logic             hitGrp;

    assign hitGrp = (int'(strb.grpSel) == g);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirIn  <= 4'hF;
        latchQ <= '0;
      end else if (strb.modeWr && hitGrp) begin
        dirIn  <= {busWdata[4], busWdata[1], busWdata[3], busWdata[0]};
        latchQ <= '0;
      end else if (strb.dataWr && hitGrp) begin
        latchQ[int'(strb.portSel)*PORT_W +: PORT_W] <= busWdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) prevQ <= 1'b0;
      else       prevQ <= syncB[g*GRP_W + 2*PORT_W + IRQ_BIT];
    end

    assign srcEdge[g] = syncB[g*GRP_W + 2*PORT_W + IRQ_BIT] & ~prevQ;
    assign pinOut[g*GRP_W +: GRP_W] = latchQ;
    assign pinOe[g*GRP_W +: PORT_W]                   = {PORT_W{~dirIn[3]}};
    assign pinOe[g*GRP_W + PORT_W +: PORT_W]          = {PORT_W{~dirIn[2]}};
    assign pinOe[g*GRP_W + 2*PORT_W +: HALF]          = {HALF{~dirIn[0]}};
    assign pinOe[g*GRP_W + 2*PORT_W + HALF +: HALF]   = {HALF{~dirIn[1]}};
  end

  assign rdView = (pinOut & pinOe) | (syncB & ~pinOe);

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (strb.rdEn)
      busRdata <= strb.rdIsData
                ? rdView[int'(strb.grpSel)*GRP_W + int'(strb.portSel)*PORT_W +: PORT_W]
                : '1;
  end
endmodule

// File: rtl/dual_ppi_gpio.sv
module dual_ppi_gpio
  import dppi_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int IRQ_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [6*PORT_W-1:0] pinIn,
  output logic [6*PORT_W-1:0] pinOut,
  output logic [6*PORT_W-1:0] pinOe,
  output logic              irqReq
);
  localparam int NUM_GRP = 2;

  ppiStrobe_t         strb;
  logic [NUM_GRP-1:0] srcEdge;

  ppi_ctrl #(.ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .modeFlag(busWdata[PORT_W-1]), .srcEdge(srcEdge), .strb(strb), .irqReq(irqReq)
  );

  ppi_datapath #(.PORT_W(PORT_W), .NUM_GRP(NUM_GRP), .IRQ_BIT(IRQ_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .busRdata(busRdata), .srcEdge(srcEdge)
  );
endmodule

// File: rtl/dual_ppi_gpio_chk.sv
module dual_ppi_gpio_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  busAddr,
  input logic        busRd,
  input logic        busWr,
  input logic        wdMode,
  input logic        wdAIn,
  input logic [7:0]  busRdata,
  input logic [47:0] pinOe,
  input logic        irqReq
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && !irqReq));

  // R3
  mode_port_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'd3 && wdMode) |=> (pinOe[7:0] == {8{!$past(wdAIn)}}));

  // R4
  no_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'd3 && !wdMode) |=> $stable(pinOe[23:0]));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[3]) |=> (busRdata == 8'hFF));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 4'hF) |=> !irqReq);

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !(busWr && busAddr == 4'hF)) |=> irqReq);
endmodule

bind dual_ppi_gpio dual_ppi_gpio_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .wdMode(busWdata[7]), .wdAIn(busWdata[4]), .busRdata(busRdata),
  .pinOe(pinOe), .irqReq(irqReq)
);

// File: tb/dual_ppi_gpio_tb.sv
module dual_ppi_gpio_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [47:0] pinIn = '0;
  logic [47:0] pinOut, pinOe;
  logic        irqReq;

  int nVec = 0, nErr = 0;
  logic [47:0] mLat = '0;
  logic [3:0]  mDir [2] = '{4'hF, 4'hF};   // {A,B,Cu,Cl}, 1 = input

  always #10 clk = ~clk;

  dual_ppi_gpio u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqReq(irqReq)
  );

  function automatic logic [47:0] expOe();
    logic [47:0] v;
    for (int g = 0; g < 2; g++) begin
      v[g*24 +: 8]      = {8{~mDir[g][3]}};
      v[g*24 + 8 +: 8]  = {8{~mDir[g][2]}};
      v[g*24 + 16 +: 4] = {4{~mDir[g][0]}};
      v[g*24 + 20 +: 4] = {4{~mDir[g][1]}};
    end
    return v;
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a);
    logic [47:0] oe, view;
    if (a[3] || a[1:0] == 2'd3) return 8'hFF;
    oe = expOe();
    view = (mLat & oe) | (pinIn & ~oe);
    return view[int'(a[2])*24 + int'(a[1:0])*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    nVec++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    if (!a[3] && a[1:0] != 2'd3) mLat[int'(a[2])*24 + int'(a[1:0])*8 +: 8] = d;
    if (!a[3] && a[1:0] == 2'd3 && d[7]) begin
      mDir[a[2]] = {d[4], d[1], d[3], d[0]};
      mLat[int'(a[2])*24 +: 24] = '0;
    end
  endtask

  task automatic busReadChk(input string tag, input logic [3:0] a);
    logic [7:0] e;
    e = expRead(a);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    chk(tag, {40'd0, busRdata}, {40'd0, e});
  endtask

  task automatic portsChk(input string tag);
    chk({tag, " oe"}, pinOe, expOe());
    chk({tag, " out"}, pinOut, mLat);
  endtask

  initial begin
    #(20 * 150000);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    logic [3:0] ra;
    void'($urandom(32'd4711));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    chk("R1 oe", pinOe, '0);
    chk("R1 out", pinOut, '0);
    chk("R1 irq", {47'd0, irqReq}, '0);

    // R2 directed: latch writes to every data port
    busWrite(4'd0, 8'hA5); busWrite(4'd1, 8'h3C); busWrite(4'd2, 8'h96);
    busWrite(4'd4, 8'h11); busWrite(4'd5, 8'h22); busWrite(4'd6, 8'h33);
    portsChk("R2 latches");

    // R3 directed mode words
    busWrite(4'd3, 8'h89); portsChk("R3 C in, A B out");
    busWrite(4'd3, 8'h81); portsChk("R3 C lower in");
    busWrite(4'd3, 8'h88); portsChk("R3 C upper in");
    busWrite(4'd7, 8'h92); portsChk("R3 group1 A B in");

    // R5 mode-set clears only its group
    busWrite(4'd4, 8'h5A); busWrite(4'd0, 8'hC3);
    busWrite(4'd3, 8'h80); portsChk("R5 group0 cleared, group1 kept");

    // R4 control write without bit 7
    busWrite(4'd2, 8'h7E);
    busWrite(4'd3, 8'h1B); portsChk("R4 ignored");

    // R6 read mix of latch and pin
    pinIn = 48'hF0F0_0F0F_AAAA;
    waitCyc(3);
    busWrite(4'd3, 8'h88);
    busWrite(4'd2, 8'hC3);
    busReadChk("R6 port C mixed", 4'd2);
    busReadChk("R6 port A output", 4'd0);
    busReadChk("R6 group1 port A input", 4'd4);
    // R7
    busReadChk("R7 ctl0", 4'd3);
    busReadChk("R7 ctl1", 4'd7);
    busReadChk("R7 unmapped", 4'd9);

    // constrained random (interrupts stay disabled)
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      ra = 4'($urandom_range(0, 5));
      ra = (ra > 4'd2) ? ra + 4'd1 : ra;
      case (op)
        0: begin busWrite(ra, 8'($urandom)); portsChk("R2 random write"); end
        1: begin
             busWrite($urandom_range(0, 1) ? 4'd7 : 4'd3, 8'($urandom));
             portsChk("R3 R4 R5 random control");
           end
        2: begin pinIn = {$urandom, $urandom}; waitCyc(3); end
        default: busReadChk("R6 R7 random read", 4'($urandom_range(0, 15)));
      endcase
    end
    chk("R9 disabled after reset", {47'd0, irqReq}, '0);

    // interrupt directed cases
    pinIn = '0; waitCyc(4);
    busWrite(4'hB, 8'h00);
    pinIn[19] = 1'b1;
    waitCyc(2); chk("R8 not before third edge", {47'd0, irqReq}, '0);
    waitCyc(1); chk("R8 raised group0", {47'd0, irqReq}, 48'd1);
    pinIn[19] = 1'b0;
    waitCyc(5); chk("R11 held after fall", {47'd0, irqReq}, 48'd1);
    busWrite(4'hF, 8'h00); chk("R10 cleared", {47'd0, irqReq}, '0);
    pinIn[20] = 1'b1; pinIn[18] = 1'b1;
    waitCyc(5); chk("R11 other pins", {47'd0, irqReq}, '0);
    pinIn[43] = 1'b1;
    waitCyc(3); chk("R8 raised group1", {47'd0, irqReq}, 48'd1);
    busWrite(4'hF, 8'h00);
    busReadChk("R9 read disable returns FF", 4'hB);
    pinIn[43] = 1'b0; waitCyc(3);
    pinIn[43] = 1'b1; pinIn[19] = 1'b1;
    waitCyc(5); chk("R9 edges ignored", {47'd0, irqReq}, '0);
    busWrite(4'hB, 8'h00);
    waitCyc(5); chk("R9 no stale edge", {47'd0, irqReq}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule